// File: doc/BRIEF.md
# Multicycle Instruction Sequencer

This block is the control sequencer for a multicycle processor core that runs a small load/store instruction subset: word load, word store, register-register arithmetic, branch-if-equal and jump. One memory port and one ALU are shared by every step of an instruction. The sequencer tells the datapath, cycle by cycle, which address feeds the memory, which operands feed the ALU and which registers and storage elements are written. It takes the 6-bit opcode field of the instruction register as its only input besides clock and reset, and holds its current step in a state register.

Each instruction first spends one cycle in fetch and one in decode. The opcode picks a path in decode. Branch and jump then finish in one more step, which gives 3 cycles. Store and register-register operations take two more steps, which gives 4 cycles. Load takes three more steps, which gives 5 cycles. An opcode the block does not recognise returns to fetch straight from decode, and nothing is written. The current step is brought out on `state_o` so that the datapath and test logic can follow the sequence.

Top module: `mc_seq_ctrl`

## Requirements
- R1: While `rst_ni` is low, `state_o` is 0 (fetch). Reset is asynchronous, and the first cycle after reset is a fetch.
- R2: Fetch (state 0) drives `mem_rd_o`=1, `addr_sel_o`=0 (PC as address), `ir_wr_o`=1, `pc_wr_o`=1, `alu_a_sel_o`=0 (PC), `alu_b_sel_o`=1 (constant 4), `alu_op_o`=0 (add) and `pc_src_o`=0 (ALU result). All other controls are 0, and the next state is decode (1).
- R3: Decode (state 1) drives `alu_a_sel_o`=0, `alu_b_sel_o`=3 (shifted offset) and `alu_op_o`=0, with no write enable set. It moves to state 2 for opcode 0x23, 5 for 0x2B, 7 for 0x00, 9 for 0x04 and 10 for 0x02.
- R4: A load visits states 0,1,2,3,4 (5 cycles). State 2 drives `alu_a_sel_o`=1 and `alu_b_sel_o`=2. State 3 drives `mem_rd_o`=1 and `addr_sel_o`=1. State 4 drives `rf_wr_o`=1, `wb_sel_o`=1 (memory data) and `dst_sel_o`=0 (rt field).
- R5: A store visits states 0,1,5,6 (4 cycles). State 5 matches state 2, and state 6 drives `mem_wr_o`=1 with `addr_sel_o`=1.
- R6: A register-register operation visits states 0,1,7,8 (4 cycles). State 7 drives `alu_a_sel_o`=1, `alu_b_sel_o`=0 and `alu_op_o`=2 (function field). State 8 drives `rf_wr_o`=1, `wb_sel_o`=0 and `dst_sel_o`=1 (rd field).
- R7: A branch visits states 0,1,9 (3 cycles). State 9 drives `alu_a_sel_o`=1, `alu_b_sel_o`=0, `alu_op_o`=1 (subtract), `pc_wr_cond_o`=1 and `pc_src_o`=1 (ALU output register).
- R8: A jump visits states 0,1,10 (3 cycles). State 10 drives `pc_wr_o`=1 and `pc_src_o`=2 (jump target).
- R9: Any other opcode in decode goes back to state 0. The block spends 2 cycles on it and asserts no write enable outside fetch.
- R10: The opcode is used only in decode. Changes on `opcode_i` in any other state leave the sequence and the outputs unchanged.
- R11: `mem_rd_o` and `mem_wr_o` are never high together, and `ir_wr_o` is high only in a fetch, which is followed by decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| opcode_i | input | 6 | Opcode field of the instruction register |
| state_o | output | 4 | Current step code |
| pc_wr_o | output | 1 | Unconditional PC write |
| pc_wr_cond_o | output | 1 | PC write gated by the ALU zero flag |
| addr_sel_o | output | 1 | Memory address: 0 PC, 1 ALU output register |
| mem_rd_o | output | 1 | Memory read |
| mem_wr_o | output | 1 | Memory write |
| ir_wr_o | output | 1 | Instruction register load |
| wb_sel_o | output | 1 | Write-back data: 0 ALU output register, 1 memory data register |
| dst_sel_o | output | 1 | Destination register: 0 rt field, 1 rd field |
| rf_wr_o | output | 1 | Register file write |
| alu_a_sel_o | output | 1 | ALU A: 0 PC, 1 register A |
| alu_b_sel_o | output | 2 | ALU B: 0 register B, 1 constant 4, 2 offset, 3 offset shifted by 2 |
| alu_op_o | output | 2 | 0 add, 1 subtract, 2 from function field |
| pc_src_o | output | 2 | PC source: 0 ALU result, 1 ALU output register, 2 jump target |

## Verification
The assertions assume that `opcode_i` may change in any cycle, and they only rely on its value in the decode step. That is where the transition for an unknown opcode is checked. The stimulus drives a new random opcode every cycle, drawn both from the five known codes and from the whole 6-bit range. This covers unknown codes and exercises the claim that the opcode is ignored outside decode. Directed runs hold each known opcode steady and count the cycles per instruction, and one asynchronous reset in the middle of a load checks the return to fetch.

// File: rtl/mc_seq_pkg.sv
package mc_seq_pkg;

  localparam int unsigned OPW   = 6;
  localparam int unsigned STW   = 4;
  localparam int unsigned SELW  = 2;

  localparam logic [OPW-1:0] OPC_LOAD   = 6'h23;
  localparam logic [OPW-1:0] OPC_STORE  = 6'h2B;
  localparam logic [OPW-1:0] OPC_ALU    = 6'h00;
  localparam logic [OPW-1:0] OPC_BRANCH = 6'h04;
  localparam logic [OPW-1:0] OPC_JUMP   = 6'h02;

  typedef enum logic [STW-1:0] {
    ST_FETCH    = 4'd0,
    ST_DECODE   = 4'd1,
    ST_LD_ADDR  = 4'd2,
    ST_LD_READ  = 4'd3,
    ST_LD_WB    = 4'd4,
    ST_ST_ADDR  = 4'd5,
    ST_ST_WRITE = 4'd6,
    ST_ALU_EXEC = 4'd7,
    ST_ALU_WB   = 4'd8,
    ST_BRANCH   = 4'd9,
    ST_JUMP     = 4'd10
  } step_e;

  typedef enum logic [2:0] {
    CL_NONE, CL_LOAD, CL_STORE, CL_ALU, CL_BRANCH, CL_JUMP
  } iclass_e;

  localparam logic [SELW-1:0] BSRC_REG    = 2'd0;
  localparam logic [SELW-1:0] BSRC_FOUR   = 2'd1;
  localparam logic [SELW-1:0] BSRC_IMM    = 2'd2;
  localparam logic [SELW-1:0] BSRC_IMM_SH = 2'd3;

  localparam logic [SELW-1:0] AOP_ADD   = 2'd0;
  localparam logic [SELW-1:0] AOP_SUB   = 2'd1;
  localparam logic [SELW-1:0] AOP_FUNCT = 2'd2;

  localparam logic [SELW-1:0] PSRC_ALU  = 2'd0;
  localparam logic [SELW-1:0] PSRC_OUT  = 2'd1;
  localparam logic [SELW-1:0] PSRC_JMP  = 2'd2;

  typedef struct packed {
    logic            pc_wr;
    logic            pc_wr_cond;
    logic            addr_sel;
    logic            mem_rd;
    logic            mem_wr;
    logic            ir_wr;
    logic            wb_sel;
    logic            dst_sel;
    logic            rf_wr;
    logic            alu_a_sel;
    logic [SELW-1:0] alu_b_sel;
    logic [SELW-1:0] alu_op;
    logic [SELW-1:0] pc_src;
  } ctrl_t;

endpackage

// File: rtl/mc_op_classify.sv
module mc_op_classify
  import mc_seq_pkg::*;
#(
  parameter int unsigned   OP_W      = OPW,
  parameter logic [OP_W-1:0] OP_LOAD   = OPC_LOAD,
  parameter logic [OP_W-1:0] OP_STORE  = OPC_STORE,
  parameter logic [OP_W-1:0] OP_ALU    = OPC_ALU,
  parameter logic [OP_W-1:0] OP_BRANCH = OPC_BRANCH,
  parameter logic [OP_W-1:0] OP_JUMP   = OPC_JUMP
) (
  input  logic [OP_W-1:0] opcode_i,
  output iclass_e         class_o
);

  always_comb begin
    if      (opcode_i == OP_LOAD)   class_o = CL_LOAD;
    else if (opcode_i == OP_STORE)  class_o = CL_STORE;
    else if (opcode_i == OP_ALU)    class_o = CL_ALU;
    else if (opcode_i == OP_BRANCH) class_o = CL_BRANCH;
    else if (opcode_i == OP_JUMP)   class_o = CL_JUMP;
    else                            class_o = CL_NONE;
  end

endmodule

// File: rtl/mc_step_next.sv
module mc_step_next
  import mc_seq_pkg::*;
(
  input  step_e   state_i,
  input  iclass_e class_i,
  output step_e   next_o
);

  always_comb begin
    next_o = ST_FETCH;
    unique case (state_i)
      ST_FETCH:    next_o = ST_DECODE;
      ST_DECODE: begin
        // class only consulted here; each path owns its own states
        unique case (class_i)
          CL_LOAD:   next_o = ST_LD_ADDR;
          CL_STORE:  next_o = ST_ST_ADDR;
          CL_ALU:    next_o = ST_ALU_EXEC;
          CL_BRANCH: next_o = ST_BRANCH;
          CL_JUMP:   next_o = ST_JUMP;
          default:   next_o = ST_FETCH;
        endcase
      end
      ST_LD_ADDR:  next_o = ST_LD_READ;
      ST_LD_READ:  next_o = ST_LD_WB;
      ST_ST_ADDR:  next_o = ST_ST_WRITE;
      ST_ALU_EXEC: next_o = ST_ALU_WB;
      default:     next_o = ST_FETCH;
    endcase
  end

endmodule

// File: rtl/mc_step_ctrl.sv
module mc_step_ctrl
  import mc_seq_pkg::*;
(
  input  step_e state_i,
  output ctrl_t ctrl_o
);

  always_comb begin
    ctrl_o = '0;
    unique case (state_i)
      ST_FETCH: begin
        ctrl_o.mem_rd    = 1'b1;
        ctrl_o.ir_wr     = 1'b1;
        ctrl_o.pc_wr     = 1'b1;
        ctrl_o.alu_b_sel = BSRC_FOUR;
        ctrl_o.alu_op    = AOP_ADD;
        ctrl_o.pc_src    = PSRC_ALU;
      end
      ST_DECODE: begin
        // branch target into ALU output register
        ctrl_o.alu_b_sel = BSRC_IMM_SH;
        ctrl_o.alu_op    = AOP_ADD;
      end
      ST_LD_ADDR, ST_ST_ADDR: begin
        ctrl_o.alu_a_sel = 1'b1;
        ctrl_o.alu_b_sel = BSRC_IMM;
        ctrl_o.alu_op    = AOP_ADD;
      end
      ST_LD_READ: begin
        ctrl_o.mem_rd    = 1'b1;
        ctrl_o.addr_sel  = 1'b1;
      end
      ST_LD_WB: begin
        ctrl_o.rf_wr     = 1'b1;
        ctrl_o.wb_sel    = 1'b1;
        ctrl_o.dst_sel   = 1'b0;
      end
      ST_ST_WRITE: begin
        ctrl_o.mem_wr    = 1'b1;
        ctrl_o.addr_sel  = 1'b1;
      end
      ST_ALU_EXEC: begin
        ctrl_o.alu_a_sel = 1'b1;
        ctrl_o.alu_b_sel = BSRC_REG;
        ctrl_o.alu_op    = AOP_FUNCT;
      end
      ST_ALU_WB: begin
        ctrl_o.rf_wr     = 1'b1;
        ctrl_o.wb_sel    = 1'b0;
        ctrl_o.dst_sel   = 1'b1;
      end
      ST_BRANCH: begin
        ctrl_o.alu_a_sel  = 1'b1;
        ctrl_o.alu_b_sel  = BSRC_REG;
        ctrl_o.alu_op     = AOP_SUB;
        ctrl_o.pc_wr_cond = 1'b1;
        ctrl_o.pc_src     = PSRC_OUT;
      end
      ST_JUMP: begin
        ctrl_o.pc_wr     = 1'b1;
        ctrl_o.pc_src    = PSRC_JMP;
      end
      default: ctrl_o = '0;
    endcase
  end

endmodule

// File: rtl/mc_seq_ctrl.sv
module mc_seq_ctrl
  import mc_seq_pkg::*;
#(
  parameter int unsigned     OP_W      = OPW,
  parameter logic [OP_W-1:0] OP_LOAD   = OPC_LOAD,
  parameter logic [OP_W-1:0] OP_STORE  = OPC_STORE,
  parameter logic [OP_W-1:0] OP_ALU    = OPC_ALU,
  parameter logic [OP_W-1:0] OP_BRANCH = OPC_BRANCH,
  parameter logic [OP_W-1:0] OP_JUMP   = OPC_JUMP
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [OP_W-1:0] opcode_i,
  output logic [STW-1:0]  state_o,
  output logic            pc_wr_o,
  output logic            pc_wr_cond_o,
  output logic            addr_sel_o,
  output logic            mem_rd_o,
  output logic            mem_wr_o,
  output logic            ir_wr_o,
  output logic            wb_sel_o,
  output logic            dst_sel_o,
  output logic            rf_wr_o,
  output logic            alu_a_sel_o,
  output logic [SELW-1:0] alu_b_sel_o,
  output logic [SELW-1:0] alu_op_o,
  output logic [SELW-1:0] pc_src_o
);

  step_e   state_q, state_d;
  iclass_e op_class;
  ctrl_t   ctrl;

  mc_op_classify #(
    .OP_W(OP_W), .OP_LOAD(OP_LOAD), .OP_STORE(OP_STORE),
    .OP_ALU(OP_ALU), .OP_BRANCH(OP_BRANCH), .OP_JUMP(OP_JUMP)
  ) u_classify (
    .opcode_i (opcode_i),
    .class_o  (op_class)
  );

  mc_step_next u_next (
    .state_i (state_q),
    .class_i (op_class),
    .next_o  (state_d)
  );

  mc_step_ctrl u_ctrl (
    .state_i (state_q),
    .ctrl_o  (ctrl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_FETCH;
    else         state_q <= state_d;
  end

  assign state_o      = state_q;
  assign pc_wr_o      = ctrl.pc_wr;
  assign pc_wr_cond_o = ctrl.pc_wr_cond;
  assign addr_sel_o   = ctrl.addr_sel;
  assign mem_rd_o     = ctrl.mem_rd;
  assign mem_wr_o     = ctrl.mem_wr;
  assign ir_wr_o      = ctrl.ir_wr;
  assign wb_sel_o     = ctrl.wb_sel;
  assign dst_sel_o    = ctrl.dst_sel;
  assign rf_wr_o      = ctrl.rf_wr;
  assign alu_a_sel_o  = ctrl.alu_a_sel;
  assign alu_b_sel_o  = ctrl.alu_b_sel;
  assign alu_op_o     = ctrl.alu_op;
  assign pc_src_o     = ctrl.pc_src;

endmodule

// File: rtl/mc_seq_ctrl_chk.sv
module mc_seq_ctrl_chk
  import mc_seq_pkg::*;
#(
  parameter int unsigned     OP_W      = OPW,
  parameter logic [OP_W-1:0] OP_LOAD   = OPC_LOAD,
  parameter logic [OP_W-1:0] OP_STORE  = OPC_STORE,
  parameter logic [OP_W-1:0] OP_ALU    = OPC_ALU,
  parameter logic [OP_W-1:0] OP_BRANCH = OPC_BRANCH,
  parameter logic [OP_W-1:0] OP_JUMP   = OPC_JUMP
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [OP_W-1:0] opcode_i,
  input logic [STW-1:0]  state_o,
  input logic            pc_wr_o,
  input logic            pc_wr_cond_o,
  input logic            addr_sel_o,
  input logic            mem_rd_o,
  input logic            mem_wr_o,
  input logic            ir_wr_o,
  input logic            wb_sel_o,
  input logic            dst_sel_o,
  input logic            rf_wr_o,
  input logic            alu_a_sel_o,
  input logic [SELW-1:0] alu_b_sel_o,
  input logic [SELW-1:0] alu_op_o,
  input logic [SELW-1:0] pc_src_o
);

  logic op_known;
  assign op_known = (opcode_i == OP_LOAD) || (opcode_i == OP_STORE) ||
                    (opcode_i == OP_ALU) || (opcode_i == OP_BRANCH) ||
                    (opcode_i == OP_JUMP);

  AST_FETCH_TO_DECODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 4'd0 |=> state_o == 4'd1); // R2

  AST_FETCH_CTRL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ir_wr_o |-> (pc_wr_o && mem_rd_o && !addr_sel_o && !alu_a_sel_o &&
                 alu_b_sel_o == 2'd1 && pc_src_o == 2'd0)); // R2

  AST_DECODE_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 4'd1 |-> !(pc_wr_o || pc_wr_cond_o || mem_wr_o || rf_wr_o || ir_wr_o)); // R3

  AST_LOAD_CHAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 4'd3 |=> (state_o == 4'd4 && rf_wr_o)); // R4

  AST_WB_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_wr_o |-> (wb_sel_o != dst_sel_o)); // R6

  AST_STORE_RETURN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |-> addr_sel_o ##1 state_o == 4'd0); // R5

  AST_ALU_CHAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 4'd7 |=> state_o == 4'd8); // R6

  AST_BRANCH_CTRL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_wr_cond_o |-> (pc_src_o == 2'd1 && !pc_wr_o && alu_op_o == 2'd1 && alu_a_sel_o)); // R7

  AST_JUMP_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_wr_o && !ir_wr_o) |-> (pc_src_o == 2'd2 ##1 state_o == 4'd0)); // R8

  AST_BAD_OPCODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 4'd1 && !op_known) |=> state_o == 4'd0); // R9

  AST_MEM_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o)); // R11

  AST_IR_ONLY_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ir_wr_o |=> state_o == 4'd1); // R11

endmodule

bind mc_seq_ctrl mc_seq_ctrl_chk #(
  .OP_W(OP_W), .OP_LOAD(OP_LOAD), .OP_STORE(OP_STORE),
  .OP_ALU(OP_ALU), .OP_BRANCH(OP_BRANCH), .OP_JUMP(OP_JUMP)
) u_chk (
  .clk_i, .rst_ni, .opcode_i, .state_o, .pc_wr_o, .pc_wr_cond_o,
  .addr_sel_o, .mem_rd_o, .mem_wr_o, .ir_wr_o, .wb_sel_o, .dst_sel_o,
  .rf_wr_o, .alu_a_sel_o, .alu_b_sel_o, .alu_op_o, .pc_src_o
);

// File: tb/mc_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module mc_seq_ctrl_tb_top;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [5:0] opcode_i = 6'h3F;
  logic [3:0] state_o;
  logic pc_wr_o, pc_wr_cond_o, addr_sel_o, mem_rd_o, mem_wr_o, ir_wr_o;
  logic wb_sel_o, dst_sel_o, rf_wr_o, alu_a_sel_o;
  logic [1:0] alu_b_sel_o, alu_op_o, pc_src_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;
  logic [3:0] model_st = 4'd0;

  always #2 clk_i = ~clk_i;

  mc_seq_ctrl dut_i (
    .clk_i, .rst_ni, .opcode_i, .state_o, .pc_wr_o, .pc_wr_cond_o,
    .addr_sel_o, .mem_rd_o, .mem_wr_o, .ir_wr_o, .wb_sel_o, .dst_sel_o,
    .rf_wr_o, .alu_a_sel_o, .alu_b_sel_o, .alu_op_o, .pc_src_o
  );

  // {pc_wr,pc_wr_cond,addr_sel,mem_rd,mem_wr,ir_wr,wb_sel,dst_sel,rf_wr,alu_a,alu_b,alu_op,pc_src}
  function automatic logic [15:0] exp_ctrl(input logic [3:0] st);
    case (st)
      4'd0:       return {10'b1001010000, 2'd1, 2'd0, 2'd0};
      4'd1:       return {10'b0000000000, 2'd3, 2'd0, 2'd0};
      4'd2, 4'd5: return {10'b0000000001, 2'd2, 2'd0, 2'd0};
      4'd3:       return {10'b0011000000, 2'd0, 2'd0, 2'd0};
      4'd4:       return {10'b0000001010, 2'd0, 2'd0, 2'd0};
      4'd6:       return {10'b0010100000, 2'd0, 2'd0, 2'd0};
      4'd7:       return {10'b0000000001, 2'd0, 2'd2, 2'd0};
      4'd8:       return {10'b0000000110, 2'd0, 2'd0, 2'd0};
      4'd9:       return {10'b0100000001, 2'd0, 2'd1, 2'd1};
      4'd10:      return {10'b1000000000, 2'd0, 2'd0, 2'd2};
      default:    return 16'h0;
    endcase
  endfunction

  function automatic logic [3:0] exp_next(input logic [3:0] st, input logic [5:0] op);
    case (st)
      4'd0: return 4'd1;
      4'd1: case (op)
              6'h23: return 4'd2;
              6'h2B: return 4'd5;
              6'h00: return 4'd7;
              6'h04: return 4'd9;
              6'h02: return 4'd10;
              default: return 4'd0;
            endcase
      4'd2: return 4'd3;
      4'd3: return 4'd4;
      4'd5: return 4'd6;
      4'd7: return 4'd8;
      default: return 4'd0;
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] st);
    case (st)
      4'd0: return "R2";
      4'd1: return "R3";
      4'd2, 4'd3, 4'd4: return "R4";
      4'd5, 4'd6: return "R5";
      4'd7, 4'd8: return "R6";
      4'd9: return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic logic [15:0] act_ctrl();
    return {pc_wr_o, pc_wr_cond_o, addr_sel_o, mem_rd_o, mem_wr_o, ir_wr_o,
            wb_sel_o, dst_sel_o, rf_wr_o, alu_a_sel_o, alu_b_sel_o, alu_op_o, pc_src_o};
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h (state %0d)", req, act, exp, model_st);
    end
  endtask

  // one cycle: sample at negedge, drive op, advance model across posedge
  task automatic step(input logic [5:0] op, input string tag);
    string r;
    r = (tag == "") ? req_of(model_st) : tag;
    check(r, {12'h0, state_o}, {12'h0, model_st});
    check(r, act_ctrl(), exp_ctrl(model_st));
    check("R11", {15'h0, mem_rd_o & mem_wr_o}, 16'h0);
    opcode_i = op;
    model_st = exp_next(model_st, op);
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic run_instr(input logic [5:0] op, input int exp_len, input string req);
    int len = 0;
    do begin
      step(op, "");
      len++;
    end while (model_st != 4'd0);
    check(req, 16'(len), 16'(exp_len));
    check(req, {12'h0, state_o}, 16'h0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
  endtask

  initial begin
    logic [5:0] known [5];
    known = '{6'h23, 6'h2B, 6'h00, 6'h04, 6'h02};
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    // R1: held in reset
    check("R1", {12'h0, state_o}, 16'h0);
    check("R1", act_ctrl(), exp_ctrl(4'd0));
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", {12'h0, state_o}, 16'h1);
    model_st = 4'd1;
    step(6'h3F, "R3");

    run_instr(6'h23, 5, "R4");
    run_instr(6'h2B, 4, "R5");
    run_instr(6'h00, 4, "R6");
    run_instr(6'h04, 3, "R7");
    run_instr(6'h02, 3, "R8");
    run_instr(6'h3F, 2, "R9");
    run_instr(6'h11, 2, "R9");

    // R1: asynchronous reset in the middle of a load
    step(6'h23, ""); step(6'h23, ""); step(6'h23, "");
    rst_ni = 1'b0;
    #1;
    check("R1", {12'h0, state_o}, 16'h0);
    model_st = 4'd0;
    @(negedge clk_i);
    check("R1", {12'h0, state_o}, 16'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    model_st = 4'd1;

    // R10: opcode changes every cycle, only decode may consult it
    for (int i = 0; i < 3000; i++) begin
      logic [5:0] op;
      op = ($urandom % 3 == 0) ? 6'($urandom) : known[$urandom % 5];
      step(op, (model_st == 4'd1 || model_st == 4'd0) ? "" : "R10");
    end

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule